// File: doc/BRIEF.md
# Host Frame Mailbox Register Block

This block sits between a host processor's 32-bit register bus and a small Ethernet MAC that has no DMA engine. Each direction has a single-frame mailbox. The host reaches each mailbox through one data register. Ownership of a mailbox passes between software and hardware through a ready bit: one side sets it and the other side clears it.

For transmit, the host pushes the frame word by word into the transmit data register. It then writes the byte length with the go bit set. The block streams ceil(length/4) words to the MAC. When the MAC reports completion, the block clears the go bit, records the error status and raises a done interrupt. For receive, the MAC streams a frame into the receive mailbox and the block sets the ready bit. The host reads the status and pulls the words out one read at a time, then writes the ready bit to zero to hand the mailbox back. A frame that arrives while software still owns the mailbox is thrown away and counted.

Both MAC-side data paths are valid/ready streams. Transmit holds `tx_valid`, `tx_data` and `tx_last` steady until the MAC accepts the beat. Receive never applies back-pressure: `rx_ready` is always high, and the block stores or discards each beat in the cycle it arrives. Data words are big-endian: the first frame byte sits in bits 31:24. Only the leading valid bytes of the final word carry frame data.

Top module: `frame_mailbox_regs`

## Requirements
- R1: After reset, the go bit, the transmit error flag, the receive ready bit, both interrupt enables and the drop count are zero. `irq` is low, `tx_valid` is low and `rx_ready` is high.
- R2: Words written to byte offset 0x808 while transmit is idle are stored in order. A write to offset 0x800 with bit 15 set starts a frame whose byte length is bits 10:0. The block then emits exactly ceil(length/4) beats carrying the stored words in order, `tx_last` is set on the final beat only, and `tx_len` shows the length.
- R3: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` stay unchanged.
- R4: After the final beat, a `tx_done` pulse ends the frame. The go bit (bit 15 of offset 0x800) then reads 0 and bit 14 reads the value of `tx_err` that came with the pulse. A frame started with length 0 ends one cycle later with no beats and with bit 14 cleared.
- R5: A write to offset 0x808 while the go bit is set is ignored and does not change any word of the frame in flight.
- R6: A write to offset 0x800 while the go bit is set is ignored: the length and the number of beats are unchanged.
- R7: A received frame that finds the mailbox free is stored word by word. On its `rx_last` beat, offset 0x810 reads with bit 15 (ready) set, bit 14 = `rx_err`, bit 13 = `rx_crc_err` and bits 10:0 = `rx_len`. Successive reads of offset 0x818 return the stored words in order.
- R8: A frame whose first beat arrives while the ready bit is set is discarded entirely. The stored words and the status remain unchanged, and `rx_drop_count` rises by one when its last beat is seen.
- R9: A write to offset 0x810 with bit 15 clear releases the mailbox: ready clears and the read position returns to the first word. A write with bit 15 set has no effect. A frame that starts after the release is stored.
- R10: `irq` is (enable bit 0 of offset 0x8C0 and receive ready) or (enable bit 1 and transmit done pending). Transmit done pending is set when a frame ends and is cleared by any write to offset 0x800.
- R11: A read asserts `bus_rvalid` with its data one cycle after `bus_rd`. Offset 0x8C0 reads back its two enable bits. The transmit data offset and unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| irq | output | 1 | Combined interrupt |
| tx_valid | output | 1 | Transmit beat valid |
| tx_ready | input | 1 | MAC accepts transmit beat |
| tx_data | output | 32 | Transmit word, first byte in bits 31:24 |
| tx_last | output | 1 | Final beat of the frame |
| tx_len | output | 11 | Byte length of the frame being sent |
| tx_done | input | 1 | MAC reports the frame is finished |
| tx_err | input | 1 | Transmit error status, sampled with tx_done |
| rx_valid | input | 1 | Receive beat valid |
| rx_ready | output | 1 | Always high: the block never stalls receive |
| rx_data | input | 32 | Receive word, first byte in bits 31:24 |
| rx_last | input | 1 | Final beat of the received frame |
| rx_len | input | 11 | Byte length, sampled with rx_last |
| rx_err | input | 1 | Receive error, sampled with rx_last |
| rx_crc_err | input | 1 | CRC error, sampled with rx_last |
| rx_drop_count | output | DROP_W | Count of discarded frames, wrapping |

## Verification
The bench builds the block with 16-word mailboxes. Frames of a few words therefore exercise the whole pointer path, while the register layout and the 11-bit length stay as in the default build. Drop counting is checked with the default counter width, since only one frame is dropped. A stalled transmit frame leaves room to check the ignored data and control writes. The receive test deliberately reads the first frame only after a second frame has been dropped, so any corruption by the dropped frame would show at the data register.

// File: rtl/fmb_pkg.sv
package fmb_pkg;
  localparam int LEN_W = 11;

  localparam logic [11:0] OFF_TX_CTL  = 12'h800;
  localparam logic [11:0] OFF_TX_DATA = 12'h808;
  localparam logic [11:0] OFF_RX_CTL  = 12'h810;
  localparam logic [11:0] OFF_RX_DATA = 12'h818;
  localparam logic [11:0] OFF_IRQ_EN  = 12'h8C0;

  localparam int TX_GO_BIT  = 15;
  localparam int TX_ERR_BIT = 14;
  localparam int RX_RDY_BIT = 15;
  localparam int RX_ERR_BIT = 14;
  localparam int RX_CRC_BIT = 13;
  localparam int IEN_RX_BIT = 0;
  localparam int IEN_TX_BIT = 1;

  typedef enum logic [1:0] {
    TXS_IDLE = 2'd0,
    TXS_SEND = 2'd1,
    TXS_WAIT = 2'd2
  } tx_state_e;
endpackage

// File: rtl/fmb_ram.sv
module fmb_ram #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 512,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/fmb_tx.sv
module fmb_tx
  import fmb_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             buf_wr,
  input  logic [31:0]      buf_wdata,
  input  logic             ctl_wr,
  input  logic             ctl_go,
  input  logic [LEN_W-1:0] ctl_len,
  output logic             busy,
  output logic             err_q,
  output logic [LEN_W-1:0] len_q,
  output logic             done_pend,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [31:0]      tx_data,
  output logic             tx_last,
  input  logic             tx_done,
  input  logic             tx_err
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  tx_state_e   state;
  logic [CW-1:0] wptr, rptr, nbeats, words_req;
  logic        load_en, beat;

  assign words_req = ({1'b0, ctl_len} + CW'(3)) >> 2;
  assign load_en   = (state == TXS_IDLE) && buf_wr && (wptr < DEPTH_C);
  assign busy      = (state != TXS_IDLE);
  assign tx_valid  = (state == TXS_SEND) && (nbeats != '0);
  assign tx_last   = tx_valid && (rptr == nbeats - CW'(1));
  assign beat      = tx_valid && tx_ready;

  fmb_ram #(.WIDTH(32), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (load_en),
    .waddr (wptr[AW-1:0]),
    .wdata (buf_wdata),
    .raddr (rptr[AW-1:0]),
    .rdata (tx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= TXS_IDLE;
      wptr      <= '0;
      rptr      <= '0;
      nbeats    <= '0;
      len_q     <= '0;
      err_q     <= 1'b0;
      done_pend <= 1'b0;
    end else begin
      if (ctl_wr) done_pend <= 1'b0;
      if (load_en) wptr <= wptr + CW'(1);
      unique case (state)
        TXS_IDLE: begin
          if (ctl_wr && ctl_go) begin
            state  <= TXS_SEND;
            len_q  <= ctl_len;
            nbeats <= (words_req > DEPTH_C) ? DEPTH_C : words_req;
            rptr   <= '0;
            wptr   <= '0;
            err_q  <= 1'b0;
          end
        end
        TXS_SEND: begin
          if (nbeats == '0) begin
            state     <= TXS_IDLE;
            done_pend <= 1'b1;
          end else if (beat) begin
            rptr <= rptr + CW'(1);
            if (tx_last) state <= TXS_WAIT;
          end
        end
        TXS_WAIT: begin
          if (tx_done) begin
            state     <= TXS_IDLE;
            err_q     <= tx_err;
            done_pend <= 1'b1;
          end
        end
        default: state <= TXS_IDLE;
      endcase
    end
  end

  // R3: a beat offered but not taken stays put
  p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R6: control writes during a frame leave the length alone
  p_ctl_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctl_wr) |=> $stable(len_q));

  // R10: done pending only rises at the end of a frame
  p_done_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_pend) |-> $past(busy));

  // R2: beats never run past the programmed count
  p_beat_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (rptr < nbeats));
endmodule

// File: rtl/fmb_rx.sv
module fmb_rx
  import fmb_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int DROP_W = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [31:0]       rx_data,
  input  logic              rx_last,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic              rx_err,
  input  logic              rx_crc_err,
  input  logic              release_wr,
  input  logic              buf_rd,
  output logic              owned,
  output logic              err_q,
  output logic              crc_q,
  output logic [LEN_W-1:0]  len_q,
  output logic [31:0]       rd_word,
  output logic [DROP_W-1:0] drop_cnt
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [CW-1:0] wptr, rptr;
  logic in_frame, discard, disc_now, keep_beat, store_en;

  assign disc_now  = in_frame ? discard : owned;
  assign keep_beat = rx_valid && !disc_now;
  assign store_en  = keep_beat && (wptr < DEPTH_C);

  fmb_ram #(.WIDTH(32), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (store_en),
    .waddr (wptr[AW-1:0]),
    .wdata (rx_data),
    .raddr (rptr[AW-1:0]),
    .rdata (rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owned    <= 1'b0;
      err_q    <= 1'b0;
      crc_q    <= 1'b0;
      len_q    <= '0;
      wptr     <= '0;
      rptr     <= '0;
      in_frame <= 1'b0;
      discard  <= 1'b0;
      drop_cnt <= '0;
    end else begin
      if (buf_rd && owned) rptr <= rptr + CW'(1);
      if (release_wr) begin
        owned <= 1'b0;
        rptr  <= '0;
      end
      if (rx_valid) begin
        in_frame <= !rx_last;
        discard  <= disc_now;
      end
      if (keep_beat) begin
        wptr <= wptr + CW'(1);
        if (rx_last) begin
          owned <= 1'b1;
          len_q <= rx_len;
          err_q <= rx_err;
          crc_q <= rx_crc_err;
          wptr  <= '0;
          rptr  <= '0;
        end
      end
      if (rx_valid && disc_now && rx_last) drop_cnt <= drop_cnt + DROP_W'(1);
    end
  end

  // R8: while software owns the mailbox its status is frozen
  p_drop_keeps_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (owned && !release_wr) |=> (owned && $stable(len_q) && $stable(err_q) && $stable(crc_q)));

  // R8: the drop count moves by single steps
  p_drop_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_cnt != $past(drop_cnt)) |-> (drop_cnt == $past(drop_cnt) + DROP_W'(1)));

  // R7: ready only rises on a final beat
  p_ready_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(owned) |-> $past(rx_valid && rx_last));
endmodule

// File: rtl/frame_mailbox_regs.sv
module frame_mailbox_regs
  import fmb_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int BUF_WORDS = 512,
  parameter int DROP_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              irq,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [31:0]       tx_data,
  output logic              tx_last,
  output logic [10:0]       tx_len,
  input  logic              tx_done,
  input  logic              tx_err,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [31:0]       rx_data,
  input  logic              rx_last,
  input  logic [10:0]       rx_len,
  input  logic              rx_err,
  input  logic              rx_crc_err,
  output logic [DROP_W-1:0] rx_drop_count
);
  logic hit_txc, hit_txd, hit_rxc, hit_rxd, hit_ien;
  logic tx_busy, tx_err_q, tx_pend, rx_owned, rx_err_q, rx_crc_q;
  logic [LEN_W-1:0] tx_len_q, rx_len_q;
  logic [31:0] rx_word, rd_mux;
  logic [1:0]  ien;

  assign hit_txc = (bus_addr == ADDR_W'(OFF_TX_CTL));
  assign hit_txd = (bus_addr == ADDR_W'(OFF_TX_DATA));
  assign hit_rxc = (bus_addr == ADDR_W'(OFF_RX_CTL));
  assign hit_rxd = (bus_addr == ADDR_W'(OFF_RX_DATA));
  assign hit_ien = (bus_addr == ADDR_W'(OFF_IRQ_EN));

  assign rx_ready = 1'b1;
  assign tx_len   = tx_len_q;

  fmb_tx #(.DEPTH(BUF_WORDS)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .buf_wr    (bus_wr && hit_txd),
    .buf_wdata (bus_wdata),
    .ctl_wr    (bus_wr && hit_txc),
    .ctl_go    (bus_wdata[TX_GO_BIT]),
    .ctl_len   (bus_wdata[LEN_W-1:0]),
    .busy      (tx_busy),
    .err_q     (tx_err_q),
    .len_q     (tx_len_q),
    .done_pend (tx_pend),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .tx_done   (tx_done),
    .tx_err    (tx_err)
  );

  fmb_rx #(.DEPTH(BUF_WORDS), .DROP_W(DROP_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_last    (rx_last),
    .rx_len     (rx_len),
    .rx_err     (rx_err),
    .rx_crc_err (rx_crc_err),
    .release_wr (bus_wr && hit_rxc && !bus_wdata[RX_RDY_BIT]),
    .buf_rd     (bus_rd && hit_rxd),
    .owned      (rx_owned),
    .err_q      (rx_err_q),
    .crc_q      (rx_crc_q),
    .len_q      (rx_len_q),
    .rd_word    (rx_word),
    .drop_cnt   (rx_drop_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ien <= '0;
    else if (bus_wr && hit_ien) ien <= bus_wdata[1:0];
  end

  always_comb begin
    rd_mux = '0;
    if (hit_txc) begin
      rd_mux[TX_GO_BIT]   = tx_busy;
      rd_mux[TX_ERR_BIT]  = tx_err_q;
      rd_mux[LEN_W-1:0]   = tx_len_q;
    end else if (hit_rxc) begin
      rd_mux[RX_RDY_BIT]  = rx_owned;
      rd_mux[RX_ERR_BIT]  = rx_err_q;
      rd_mux[RX_CRC_BIT]  = rx_crc_q;
      rd_mux[LEN_W-1:0]   = rx_len_q;
    end else if (hit_rxd) begin
      rd_mux = rx_word;
    end else if (hit_ien) begin
      rd_mux[1:0] = ien;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  assign irq = (ien[IEN_RX_BIT] && rx_owned) || (ien[IEN_TX_BIT] && tx_pend);

  // R11: one-cycle read latency
  p_read_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  // R10: the end of a frame with the done enable set raises the line
  p_tx_done_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tx_busy) && ien[IEN_TX_BIT]) |-> irq);

  // R10: no enables, no interrupt
  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == 2'b00) |-> !irq);
endmodule

// File: tb/frame_mailbox_regs_bench.sv
module frame_mailbox_regs_bench;
  localparam int ADDR_W = 12;
  localparam int DROP_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid, irq;
  logic tx_valid, tx_last;
  logic tx_ready = 1'b1;
  logic [31:0] tx_data;
  logic [10:0] tx_len;
  logic tx_done = 1'b0, tx_err = 1'b0;
  logic rx_valid = 1'b0, rx_last = 1'b0, rx_err = 1'b0, rx_crc_err = 1'b0;
  logic rx_ready;
  logic [31:0] rx_data = '0;
  logic [10:0] rx_len = '0;
  logic [DROP_W-1:0] rx_drop_count;

  int total = 0;
  int bad = 0;
  logic [31:0] fw [8];
  logic [31:0] cap [16];
  logic        caplast [16];
  int got;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  frame_mailbox_regs #(.ADDR_W(ADDR_W), .BUF_WORDS(16), .DROP_W(DROP_W)) u_frame_mailbox_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq(irq),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .tx_len(tx_len), .tx_done(tx_done), .tx_err(tx_err),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last),
    .rx_len(rx_len), .rx_err(rx_err), .rx_crc_err(rx_crc_err), .rx_drop_count(rx_drop_count)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R11 rvalid", {31'b0, bus_rvalid}, 32'd1);
    d = bus_rdata;
  endtask

  task automatic collect(input int cycles);
    got = 0;
    repeat (cycles) begin
      if (tx_valid && tx_ready && got < 16) begin
        cap[got] = tx_data; caplast[got] = tx_last; got++;
      end
      @(negedge clk);
    end
  endtask

  task automatic mac_done(input logic e);
    @(negedge clk);
    tx_done = 1'b1; tx_err = e;
    @(negedge clk);
    tx_done = 1'b0; tx_err = 1'b0;
  endtask

  task automatic rx_send(input int n, input logic [10:0] l, input logic e, input logic c);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = fw[i]; rx_last = (i == n - 1);
      rx_len = l; rx_err = e; rx_crc_err = c;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0; rx_crc_err = 1'b0;
  endtask

  task automatic t_reset;
    reg_rd(12'h800, rd); chk("R1 tx ctl", rd, 32'h0);
    reg_rd(12'h810, rd); chk("R1 rx ctl", rd, 32'h0);
    reg_rd(12'h8C0, rd); chk("R1 irq enables", rd, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'd0);
    chk("R1 tx_valid", {31'b0, tx_valid}, 32'd0);
    chk("R1 rx_ready", {31'b0, rx_ready}, 32'd1);
    chk("R1 drop count", 32'(rx_drop_count), 32'd0);
  endtask

  task automatic t_regs;
    reg_wr(12'h8C0, 32'hFFFF_FFFF);
    reg_rd(12'h8C0, rd); chk("R11 enable readback", rd, 32'h3);
    reg_rd(12'h804, rd); chk("R11 unmapped", rd, 32'h0);
    reg_rd(12'h808, rd); chk("R11 tx data reads zero", rd, 32'h0);
    reg_wr(12'h8C0, 32'h0);
  endtask

  task automatic t_tx_basic;
    reg_wr(12'h8C0, 32'h2);
    reg_wr(12'h808, 32'hA0A1_A2A3);
    reg_wr(12'h808, 32'hB0B1_B2B3);
    reg_wr(12'h808, 32'hC0C1_0000);
    reg_wr(12'h800, 32'h0000_800A);
    chk("R2 tx_len", 32'(tx_len), 32'd10);
    tx_ready = 1'b1;
    collect(8);
    chk("R2 beat count", got, 32'd3);
    chk("R2 word0", cap[0], 32'hA0A1_A2A3);
    chk("R2 word1", cap[1], 32'hB0B1_B2B3);
    chk("R2 word2", cap[2], 32'hC0C1_0000);
    chk("R2 last flags", {29'b0, caplast[0], caplast[1], caplast[2]}, 32'b001);
    reg_rd(12'h800, rd); chk("R4 go held until done", rd, 32'h0000_800A);
    chk("R10 no irq before done", {31'b0, irq}, 32'd0);
    mac_done(1'b0);
    reg_rd(12'h800, rd); chk("R4 go cleared", rd, 32'h0000_000A);
    chk("R10 tx done irq", {31'b0, irq}, 32'd1);
    reg_wr(12'h800, 32'h0);
    chk("R10 irq cleared by tx ctl write", {31'b0, irq}, 32'd0);
  endtask

  task automatic t_tx_stall;
    reg_wr(12'h808, 32'h1111_2222);
    reg_wr(12'h808, 32'h3333_4444);
    tx_ready = 1'b0;
    reg_wr(12'h800, 32'h0000_8008);
    chk("R3 valid under stall", {31'b0, tx_valid}, 32'd1);
    chk("R3 data under stall", tx_data, 32'h1111_2222);
    reg_wr(12'h808, 32'hDEAD_BEEF);
    reg_wr(12'h800, 32'h0000_8004);
    chk("R3 still held", tx_data, 32'h1111_2222);
    reg_rd(12'h800, rd); chk("R6 ctl write ignored", rd, 32'h0000_8008);
    chk("R6 tx_len kept", 32'(tx_len), 32'd8);
    tx_ready = 1'b1;
    collect(8);
    chk("R6 beat count", got, 32'd2);
    chk("R5 word0 intact", cap[0], 32'h1111_2222);
    chk("R5 word1 intact", cap[1], 32'h3333_4444);
    mac_done(1'b1);
    reg_rd(12'h800, rd); chk("R4 error captured", rd, 32'h0000_4008);
    reg_wr(12'h800, 32'h0);
  endtask

  task automatic t_tx_zero;
    reg_wr(12'h800, 32'h0000_8000);
    collect(4);
    chk("R4 zero length no beats", got, 32'd0);
    reg_rd(12'h800, rd); chk("R4 zero length done", rd, 32'h0);
    reg_wr(12'h800, 32'h0);
  endtask

  task automatic t_rx;
    reg_wr(12'h8C0, 32'h1);
    fw[0] = 32'h0102_0304; fw[1] = 32'h0506_0708; fw[2] = 32'h090A_0B00;
    rx_send(3, 11'd11, 1'b1, 1'b0);
    chk("R10 rx irq", {31'b0, irq}, 32'd1);
    reg_rd(12'h810, rd); chk("R7 rx status", rd, 32'h0000_C00B);
    fw[0] = 32'hEEEE_EEEE; fw[1] = 32'hFFFF_FFFF;
    rx_send(2, 11'd8, 1'b0, 1'b1);
    chk("R8 drop counted", 32'(rx_drop_count), 32'd1);
    reg_rd(12'h810, rd); chk("R8 status unchanged", rd, 32'h0000_C00B);
    reg_rd(12'h818, rd); chk("R7 rx word0", rd, 32'h0102_0304);
    reg_rd(12'h818, rd); chk("R7 rx word1", rd, 32'h0506_0708);
    reg_rd(12'h818, rd); chk("R8 rx word2 intact", rd, 32'h090A_0B00);
    reg_wr(12'h810, 32'h0000_8000);
    reg_rd(12'h810, rd); chk("R9 set-bit write no release", rd, 32'h0000_C00B);
    reg_wr(12'h810, 32'h0);
    chk("R9 irq drops on release", {31'b0, irq}, 32'd0);
    reg_rd(12'h810, rd); chk("R9 ready cleared", rd, 32'h0000_400B);
    fw[0] = 32'h5566_7788;
    rx_send(1, 11'd4, 1'b0, 1'b1);
    reg_rd(12'h810, rd); chk("R9 new frame stored", rd, 32'h0000_A004);
    reg_rd(12'h818, rd); chk("R9 new frame word", rd, 32'h5566_7788);
    chk("R8 no extra drop", 32'(rx_drop_count), 32'd1);
    reg_wr(12'h810, 32'h0);
    reg_wr(12'h8C0, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_regs;
    t_tx_basic;
    t_tx_stall;
    t_tx_zero;
    t_rx;
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule